// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block sits between instruction issue and execute. When a vector-prefixed scalar instruction arrives, it freezes the main program counter and runs a hardware loop over the instruction's elements. Each step adds an auto-incrementing element offset to the source and destination base register numbers. One instruction therefore covers a run of consecutive registers in a 128-entry register space. A vector length of 1 gives exactly the plain scalar instruction.

The source side and the destination side each have their own predicate mask and their own step counter. A masked-out slot on either side is skipped, so each element is read from the next enabled source slot and written to the next enabled destination slot. With only one side predicated, the loop compresses (source masked) or expands (destination masked). The vector length and both step counters form a state that can be saved and written back through a restore path, so an interrupted loop resumes where it stopped. In fail-first mode, a failing per-element test ends the loop early and truncates the vector length at that element.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset the block is idle: pc_hold_o, issue_o and done_o are low, vl_o is 1, and both step outputs are 0.
- R2: start_i while idle captures the bases, masks and mode bits, and raises pc_hold_o from the next cycle. Without predication, the block issues one element per cycle with src_reg_o = src_base + source step and dst_reg_o = dst_base + destination step, and both steps advance by one after each issue.
- R3: In a busy cycle where either step is at or above vl_o, done_o is high for exactly that cycle and issue_o is low. In the next cycle pc_hold_o is low and both steps are 0.
- R4: A length of 1 issues exactly one element, at the base registers. A length of 0 issues nothing and ends with done_o.
- R5: With source predication enabled, source element i is enabled when bit i of src_mask_i is 1. In a cycle where the current source slot is disabled, nothing issues and the source step advances. If the destination slot is also disabled in that cycle, the destination step advances in the same cycle.
- R6: With destination predication enabled, destination element i is enabled when bit i of dst_mask_i is 1. In a cycle where the source slot is enabled and the destination slot is disabled, nothing issues and only the destination step advances.
- R7: With only the source side predicated the loop compresses the enabled source elements into consecutive destinations. With only the destination side predicated it expands consecutive sources into the enabled destinations.
- R8: restore_i loads the vector length (clamped to MAX_VL), the source step and the destination step, and leaves the block idle, even in mid-loop. It wins over start_i in the same cycle. A later start resumes the loop from the loaded steps.
- R9: In fail-first mode, if test_fail_i is high during an issue, vl_o becomes the destination step when the failing element is excluded, or the destination step plus 1 when it is included, and the loop ends in the following cycle. wr_en_o follows issue_o, except that it is low for an excluded failing element.
- R10: Register numbers are 7 bits wide and wrap modulo 128.
- R11: While busy, start_i and changes to the base, mask and mode inputs have no effect on the running loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin the loop for one instruction |
| src_base_i | input | 7 | Source base register number |
| dst_base_i | input | 7 | Destination base register number |
| src_pred_en_i | input | 1 | Enable source predication |
| src_mask_i | input | MAX_VL | Source predicate mask, bit i for element i |
| dst_pred_en_i | input | 1 | Enable destination predication |
| dst_mask_i | input | MAX_VL | Destination predicate mask, bit i for element i |
| ffirst_en_i | input | 1 | Enable data-dependent fail-first |
| ffirst_incl_i | input | 1 | Keep the failing element in the truncated length |
| test_fail_i | input | 1 | Test result for the element issued this cycle |
| restore_i | input | 1 | Load the step state |
| restore_vl_i | input | 7 | Vector length to load |
| restore_src_step_i | input | 7 | Source step to load |
| restore_dst_step_i | input | 7 | Destination step to load |
| pc_hold_o | output | 1 | Program counter held, loop busy |
| issue_o | output | 1 | Element issue strobe |
| wr_en_o | output | 1 | Result write enable for the issued element |
| src_reg_o | output | 7 | Source register number |
| dst_reg_o | output | 7 | Destination register number |
| done_o | output | 1 | Loop finished, one cycle |
| vl_o | output | 7 | Current vector length |
| src_step_o | output | 7 | Current source step |
| dst_step_o | output | 7 | Current destination step |

## Verification
The hardest situation to reach from the ports is a loop that resumes from an uneven pair of steps, with both masks active and a fail-first truncation partway through. In that case the two counters disagree and the truncated length depends on the destination side only. The stimulus reaches it by writing arbitrary steps through the restore path before a start. It then places the failing test at a chosen destination index, which the bench reads from its own model rather than from the design.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
    localparam int DEF_MAX_VL   = 64;
    localparam int DEF_REG_BITS = 7;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_FINISH,
        ACT_SKIP,
        ACT_ISSUE
    } step_act_e;
endpackage

// File: rtl/elem_pred_gate.sv
module elem_pred_gate #(
    parameter int MAX_VL = 64,
    parameter int SW     = 7
) (
    input  logic              pred_en,
    input  logic [MAX_VL-1:0] mask,
    input  logic [SW-1:0]     step,
    output logic              enabled
);
    localparam int IW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

    logic [IW-1:0] idx;
    assign idx     = step[IW-1:0];
    assign enabled = !pred_en || mask[idx];
endmodule

// File: rtl/elem_reg_offset.sv
module elem_reg_offset #(
    parameter int RB = 7,
    parameter int SW = 7
) (
    input  logic [RB-1:0] base,
    input  logic [SW-1:0] step,
    output logic [RB-1:0] reg_num
);
    assign reg_num = base + RB'(step);
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
    import elem_loop_pkg::*;
#(
    parameter int MAX_VL   = DEF_MAX_VL,
    parameter int REG_BITS = DEF_REG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [REG_BITS-1:0] src_base_i,
    input  logic [REG_BITS-1:0] dst_base_i,
    input  logic                src_pred_en_i,
    input  logic [MAX_VL-1:0]   src_mask_i,
    input  logic                dst_pred_en_i,
    input  logic [MAX_VL-1:0]   dst_mask_i,
    input  logic                ffirst_en_i,
    input  logic                ffirst_incl_i,
    input  logic                test_fail_i,
    input  logic                restore_i,
    input  logic [$clog2(MAX_VL+1)-1:0] restore_vl_i,
    input  logic [$clog2(MAX_VL+1)-1:0] restore_src_step_i,
    input  logic [$clog2(MAX_VL+1)-1:0] restore_dst_step_i,
    output logic                pc_hold_o,
    output logic                issue_o,
    output logic                wr_en_o,
    output logic [REG_BITS-1:0] src_reg_o,
    output logic [REG_BITS-1:0] dst_reg_o,
    output logic                done_o,
    output logic [$clog2(MAX_VL+1)-1:0] vl_o,
    output logic [$clog2(MAX_VL+1)-1:0] src_step_o,
    output logic [$clog2(MAX_VL+1)-1:0] dst_step_o
);
    localparam int SW = $clog2(MAX_VL + 1);
    localparam logic [SW-1:0] VL_CAP = SW'(MAX_VL);

    typedef struct packed {
        logic                busy;
        logic [SW-1:0]       vl;
        logic [SW-1:0]       sstep;
        logic [SW-1:0]       dstep;
        logic [REG_BITS-1:0] sbase;
        logic [REG_BITS-1:0] dbase;
        logic                spred;
        logic                dpred;
        logic                ffirst;
        logic                fincl;
        logic [MAX_VL-1:0]   smask;
        logic [MAX_VL-1:0]   dmask;
    } loop_st_t;

    loop_st_t  st_q, st_d;
    step_act_e act_d;
    logic      src_ok, dst_ok, fail_hit, wr_d;

    // Per-side predicate gating: source side and destination side.
    elem_pred_gate #(.MAX_VL(MAX_VL), .SW(SW)) u_src_gate (
        .pred_en(st_q.spred), .mask(st_q.smask), .step(st_q.sstep), .enabled(src_ok)
    );
    elem_pred_gate #(.MAX_VL(MAX_VL), .SW(SW)) u_dst_gate (
        .pred_en(st_q.dpred), .mask(st_q.dmask), .step(st_q.dstep), .enabled(dst_ok)
    );

    elem_reg_offset #(.RB(REG_BITS), .SW(SW)) u_src_off (
        .base(st_q.sbase), .step(st_q.sstep), .reg_num(src_reg_o)
    );
    elem_reg_offset #(.RB(REG_BITS), .SW(SW)) u_dst_off (
        .base(st_q.dbase), .step(st_q.dstep), .reg_num(dst_reg_o)
    );

    always_comb begin
        st_d     = st_q;
        act_d    = ACT_IDLE;
        fail_hit = 1'b0;
        wr_d     = 1'b0;
        if (st_q.busy) begin
            if (st_q.sstep >= st_q.vl || st_q.dstep >= st_q.vl) begin
                act_d       = ACT_FINISH;
                st_d.busy   = 1'b0;
                st_d.sstep  = '0;
                st_d.dstep  = '0;
            end else if (!src_ok) begin
                act_d      = ACT_SKIP;
                st_d.sstep = st_q.sstep + 1'b1;
                if (!dst_ok) st_d.dstep = st_q.dstep + 1'b1;
            end else if (!dst_ok) begin
                act_d      = ACT_SKIP;
                st_d.dstep = st_q.dstep + 1'b1;
            end else begin
                act_d      = ACT_ISSUE;
                fail_hit   = st_q.ffirst && test_fail_i;
                wr_d       = !(fail_hit && !st_q.fincl);
                st_d.sstep = st_q.sstep + 1'b1;
                st_d.dstep = st_q.dstep + 1'b1;
                if (fail_hit)
                    st_d.vl = st_q.fincl ? st_q.dstep + 1'b1 : st_q.dstep;
            end
        end
        if (restore_i) begin
            st_d.busy  = 1'b0;
            st_d.vl    = (restore_vl_i > VL_CAP) ? VL_CAP : restore_vl_i;
            st_d.sstep = restore_src_step_i;
            st_d.dstep = restore_dst_step_i;
        end else if (start_i && !st_q.busy) begin
            st_d.busy   = 1'b1;
            st_d.sbase  = src_base_i;
            st_d.dbase  = dst_base_i;
            st_d.spred  = src_pred_en_i;
            st_d.dpred  = dst_pred_en_i;
            st_d.smask  = src_mask_i;
            st_d.dmask  = dst_mask_i;
            st_d.ffirst = ffirst_en_i;
            st_d.fincl  = ffirst_incl_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.vl <= SW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_hold_o  = st_q.busy;
    assign issue_o    = (act_d == ACT_ISSUE);
    assign done_o     = (act_d == ACT_FINISH);
    assign wr_en_o    = wr_d;
    assign vl_o       = st_q.vl;
    assign src_step_o = st_q.sstep;
    assign dst_step_o = st_q.dstep;

    a_r2_issue_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> pc_hold_o);
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !restore_i) |=> (!pc_hold_o && src_step_o == '0 && dst_step_o == '0));
    a_r8_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (!pc_hold_o && src_step_o == $past(restore_src_step_i)
                       && dst_step_o == $past(restore_dst_step_i)));
    a_r9_include_len: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && st_q.ffirst && st_q.fincl && test_fail_i && !restore_i)
        |=> (vl_o == $past(dst_step_o) + 1'b1));
    a_r9_write_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> issue_o);
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold_o && !done_o && !restore_i) |=> pc_hold_o);
endmodule

// File: tb/elem_loop_seq_test.sv
module elem_loop_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, src_pred_en_i = 0, dst_pred_en_i = 0;
    logic ffirst_en_i = 0, ffirst_incl_i = 0, test_fail_i = 0, restore_i = 0;
    logic [6:0] src_base_i = 0, dst_base_i = 0;
    logic [63:0] src_mask_i = 0, dst_mask_i = 0;
    logic [6:0] restore_vl_i = 0, restore_src_step_i = 0, restore_dst_step_i = 0;
    logic pc_hold_o, issue_o, wr_en_o, done_o;
    logic [6:0] src_reg_o, dst_reg_o, vl_o, src_step_o, dst_step_o;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    int fail_idx = -1;

    int m_busy = 0, m_vl = 1, m_s = 0, m_d = 0, m_sb = 0, m_db = 0;
    int m_sp = 0, m_dp = 0, m_ff = 0, m_fi = 0;
    logic [63:0] m_sm = 0, m_dm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    elem_loop_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_base_i(src_base_i), .dst_base_i(dst_base_i),
        .src_pred_en_i(src_pred_en_i), .src_mask_i(src_mask_i),
        .dst_pred_en_i(dst_pred_en_i), .dst_mask_i(dst_mask_i),
        .ffirst_en_i(ffirst_en_i), .ffirst_incl_i(ffirst_incl_i),
        .test_fail_i(test_fail_i), .restore_i(restore_i),
        .restore_vl_i(restore_vl_i), .restore_src_step_i(restore_src_step_i),
        .restore_dst_step_i(restore_dst_step_i),
        .pc_hold_o(pc_hold_o), .issue_o(issue_o), .wr_en_o(wr_en_o),
        .src_reg_o(src_reg_o), .dst_reg_o(dst_reg_o), .done_o(done_o),
        .vl_o(vl_o), .src_step_o(src_step_o), .dst_step_o(dst_step_o)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // One clock of the reference model, compared against the design.
    task automatic cyc();
        int e_issue = 0, e_done = 0, e_wr = 0;
        int n_busy = m_busy, n_vl = m_vl, n_s = m_s, n_d = m_d;
        bit s_ok, d_ok, fail;
        test_fail_i = (m_busy != 0) && (m_d == fail_idx);
        #1;
        if (m_busy != 0) begin
            if (m_s >= m_vl || m_d >= m_vl) begin
                e_done = 1; n_busy = 0; n_s = 0; n_d = 0;
            end else begin
                s_ok = (m_sp == 0) || m_sm[m_s];
                d_ok = (m_dp == 0) || m_dm[m_d];
                if (!s_ok) begin
                    n_s = m_s + 1;
                    if (!d_ok) n_d = m_d + 1;
                end else if (!d_ok) begin
                    n_d = m_d + 1;
                end else begin
                    e_issue = 1;
                    fail = (m_ff != 0) && test_fail_i;
                    e_wr = (fail && m_fi == 0) ? 0 : 1;
                    n_s = m_s + 1; n_d = m_d + 1;
                    if (fail) n_vl = (m_fi != 0) ? m_d + 1 : m_d;
                end
            end
        end
        chk("pc_hold", int'(pc_hold_o), m_busy);
        chk("issue", int'(issue_o), e_issue);
        chk("wr_en", int'(wr_en_o), e_wr);
        chk("done", int'(done_o), e_done);
        chk("vl", int'(vl_o), m_vl);
        chk("src_step", int'(src_step_o), m_s);
        chk("dst_step", int'(dst_step_o), m_d);
        if (e_issue != 0) begin
            chk("src_reg", int'(src_reg_o), (m_sb + m_s) % 128);
            chk("dst_reg", int'(dst_reg_o), (m_db + m_d) % 128);
        end
        if (restore_i) begin
            n_busy = 0;
            n_vl = (int'(restore_vl_i) > MAX_VL) ? MAX_VL : int'(restore_vl_i);
            n_s = restore_src_step_i; n_d = restore_dst_step_i;
        end else if (start_i && m_busy == 0) begin
            n_busy = 1;
            m_sb = src_base_i; m_db = dst_base_i;
            m_sp = src_pred_en_i; m_dp = dst_pred_en_i;
            m_sm = src_mask_i; m_dm = dst_mask_i;
            m_ff = ffirst_en_i; m_fi = ffirst_incl_i;
        end
        @(posedge clk);
        m_busy = n_busy; m_vl = n_vl; m_s = n_s; m_d = n_d;
        @(negedge clk);
    endtask

    task automatic do_restore(int vl, int s, int d);
        restore_vl_i = 7'(vl); restore_src_step_i = 7'(s); restore_dst_step_i = 7'(d);
        restore_i = 1; cyc(); restore_i = 0;
    endtask

    task automatic do_start(int sb, int db, bit sp, logic [63:0] sm, bit dp,
                            logic [63:0] dm, bit ff, bit fi);
        src_base_i = 7'(sb); dst_base_i = 7'(db);
        src_pred_en_i = sp; src_mask_i = sm; dst_pred_en_i = dp; dst_mask_i = dm;
        ffirst_en_i = ff; ffirst_incl_i = fi;
        start_i = 1; cyc(); start_i = 0;
    endtask

    task automatic run_out();
        for (int i = 0; i < 200 && m_busy != 0; i++) cyc();
        cyc();
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        cyc(); cyc();

        cur_req = "R2";
        do_restore(5, 0, 0);
        do_start(10, 20, 0, 0, 0, 0, 0, 0);
        run_out();

        cur_req = "R4";
        do_restore(1, 0, 0);
        do_start(3, 4, 0, 0, 0, 0, 0, 0);
        run_out();
        do_restore(0, 0, 0);
        do_start(3, 4, 0, 0, 0, 0, 0, 0);
        run_out();

        cur_req = "R5";
        do_restore(6, 0, 0);
        do_start(0, 40, 1, 64'b101101, 1, 64'b010111, 0, 0);
        run_out();

        cur_req = "R6";
        do_restore(5, 0, 0);
        do_start(8, 16, 0, 0, 1, 64'b11010, 0, 0);
        run_out();

        cur_req = "R7";
        do_restore(5, 0, 0);
        do_start(8, 16, 1, 64'b10110, 0, 0, 0, 0);
        run_out();

        cur_req = "R8";
        do_restore(6, 1, 2);
        do_start(30, 50, 1, 64'b111010, 1, 64'b101100, 0, 0);
        run_out();
        do_restore(8, 0, 0);
        do_start(1, 2, 0, 0, 0, 0, 0, 0);
        cyc(); cyc();
        do_restore(4, 0, 0);
        cyc();
        restore_i = 1; start_i = 1; restore_vl_i = 7'd3;
        restore_src_step_i = 0; restore_dst_step_i = 0;
        cyc(); restore_i = 0; start_i = 0;
        cyc();
        do_restore(100, 0, 0);
        cyc();

        cur_req = "R9";
        fail_idx = 3;
        do_restore(8, 0, 0);
        do_start(0, 0, 0, 0, 0, 0, 1, 0);
        run_out();
        fail_idx = 2;
        do_restore(8, 1, 0);
        do_start(0, 0, 1, 64'b11111101, 0, 0, 1, 1);
        run_out();
        fail_idx = -1;

        cur_req = "R10";
        do_restore(6, 0, 0);
        do_start(125, 127, 0, 0, 0, 0, 0, 0);
        run_out();

        cur_req = "R11";
        do_restore(6, 0, 0);
        do_start(5, 6, 1, 64'b111111, 0, 0, 0, 0);
        src_mask_i = 0; src_base_i = 7'd90; ffirst_en_i = 1;
        cyc();
        start_i = 1; cyc(); start_i = 0;
        run_out();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule